// File: doc/BRIEF.md
# Asynchronous Static RAM Sequencer

This block lets a clocked host read and write an external 8K x 8 asynchronous static RAM. The host presents one request at a time on a valid/ready handshake with an address, a write flag and write data. When the request finishes, the block returns a one-cycle completion pulse and, for reads, the byte it captured. On the memory side it drives an active-low select and an active-high select, an active-low write strobe and an active-low output enable, together with a registered address bus and a split data bus (outgoing byte, incoming byte, drive enable). Pad tri-stating is left to the chip level.

Every strobe phase lasts a whole number of clock cycles, set by parameters. A state machine walks through named phases. **IDLE** holds the memory in standby with both selects off. **RD_ACCESS** turns the selects on and pulls output enable low for `CYC_ACCESS` cycles, and captures the byte on its last cycle. **RD_TURN** releases output enable and the selects for `CYC_TURN` cycles, so the memory's drivers are off before the controller drives the bus again. **WR_SETUP** (one cycle) turns the selects on and puts address and data on the bus. **WR_PULSE** holds the write strobe low for the larger of `CYC_WP` and `CYC_DW`, with output enable kept high. **WR_HOLD** raises the write strobe while the selects, address and data stay put for `CYC_HOLD` cycles.

The transitions are:
- IDLE→RD_ACCESS on an accepted read.
- IDLE→WR_SETUP on an accepted write.
- RD_ACCESS→RD_TURN, RD_TURN→IDLE, WR_SETUP→WR_PULSE, WR_PULSE→WR_HOLD and WR_HOLD→IDLE, each when its phase counter expires.

The defaults (2/2/1/1/1) suit a 15 ns part clocked at up to 100 MHz. All parameters must be at least 1.

Top module: `sramc_ctrl`

## Requirements
- R1: After reset, and whenever no access is in progress, the memory outputs are: active-low select 1, active-high select 0, write strobe 1, output enable 1, drive enable 0. In this state `req_ready` is 1 and `rsp_done` is 0.
- R2: A request is taken only when `req_valid` and `req_ready` are both 1, and `req_ready` is 1 only in IDLE. A `req_valid` raised while busy and withdrawn before IDLE causes no memory write and no completion pulse.
- R3: A read holds both selects active, output enable low, the write strobe high and drive enable low for `CYC_ACCESS` cycles. It captures the memory byte on the last of those cycles and raises `rsp_done` `CYC_ACCESS+CYC_TURN` cycles after the accepting edge, with `rsp_rdata` holding that byte.
- R4: After output enable rises at the end of a read, drive enable stays 0 for at least `CYC_TURN+1` cycles.
- R5: A write holds the write strobe low only while both selects are active and drive enable is 1, for exactly max(`CYC_WP`,`CYC_DW`) consecutive cycles. `rsp_done` follows `1+max(CYC_WP,CYC_DW)+CYC_HOLD` cycles after the accepting edge.
- R6: Output enable is never low while the write strobe is low, and drive enable is never 1 while output enable is low.
- R7: While the selects stay active, the address does not change. While the write strobe stays low, the outgoing data does not change.
- R8: `rsp_done` lasts exactly one cycle. `rsp_rdata` keeps the last captured byte until the next read completes, so writes leave it unchanged.
- R9: A read returns the byte most recently written to that address, at any address from 0 to 8191.
- R10: In the cycle where `rsp_done` is high, both selects are inactive, so accesses are always separated by at least one standby cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can take a request (IDLE) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Last byte read |
| mem_addr | output | 13 | Memory address bus |
| mem_cs_n | output | 1 | Active-low memory select |
| mem_cs | output | 1 | Active-high memory select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dout | output | 8 | Byte driven toward the memory |
| mem_din | input | 8 | Byte returned by the memory |
| mem_drive | output | 1 | Controller drives the data bus |

## Verification
The bench covers these failure modes:
- A read followed at once by a write. If the turnaround phase were missing, the write data would hit the bus while the memory still drives it, and the bus model would report both sides driving.
- Write strobe pulse width. A pulse one cycle short or long fails the pulse count.
- Output enable during writes. Output enable left low while the strobe is low would be flagged.
- A request raised and withdrawn while busy. If such a request leaked through, a stray completion would appear, or the untouched address would read back a different byte.
- Addresses 0 and 8191, read-after-write and write-after-read. An off-by-one in the capture cycle returns the idle filler byte instead of the stored one.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_RD_ACCESS = 3'd1,
        ST_RD_TURN   = 3'd2,
        ST_WR_SETUP  = 3'd3,
        ST_WR_PULSE  = 3'd4,
        ST_WR_HOLD   = 3'd5
    } sram_state_e;

    function automatic int unsigned larger_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sramc_phase_timer.sv
module sramc_phase_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == '0);

endmodule

// File: rtl/sramc_fsm.sv
module sramc_fsm
    import sramc_pkg::*;
#(
    parameter int CNT_W      = 2,
    parameter int LEN_ACCESS = 2,
    parameter int LEN_TURN   = 1,
    parameter int LEN_PULSE  = 2,
    parameter int LEN_HOLD   = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             phase_last,
    output logic             load,
    output logic [CNT_W-1:0] load_val,
    output logic             accept,
    output logic             capture,
    output logic             ready,
    output logic             done,
    output logic             cs_n,
    output logic             cs,
    output logic             we_n,
    output logic             oe_n,
    output logic             drive
);

    localparam logic [CNT_W-1:0] LV_ACCESS = CNT_W'(LEN_ACCESS - 1);
    localparam logic [CNT_W-1:0] LV_TURN   = CNT_W'(LEN_TURN - 1);
    localparam logic [CNT_W-1:0] LV_PULSE  = CNT_W'(LEN_PULSE - 1);
    localparam logic [CNT_W-1:0] LV_HOLD   = CNT_W'(LEN_HOLD - 1);

    sram_state_e state_q, state_n;

    // next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:      if (req_valid) state_n = req_write ? ST_WR_SETUP : ST_RD_ACCESS;
            ST_RD_ACCESS: if (phase_last) state_n = ST_RD_TURN;
            ST_RD_TURN:   if (phase_last) state_n = ST_IDLE;
            ST_WR_SETUP:  if (phase_last) state_n = ST_WR_PULSE;
            ST_WR_PULSE:  if (phase_last) state_n = ST_WR_HOLD;
            ST_WR_HOLD:   if (phase_last) state_n = ST_IDLE;
            default:      state_n = ST_IDLE;
        endcase
    end

    // phase length of the state about to be entered
    always_comb begin
        load_val = '0;
        unique case (state_n)
            ST_RD_ACCESS: load_val = LV_ACCESS;
            ST_RD_TURN:   load_val = LV_TURN;
            ST_WR_PULSE:  load_val = LV_PULSE;
            ST_WR_HOLD:   load_val = LV_HOLD;
            default:      load_val = '0;
        endcase
    end

    assign load    = (state_n != state_q);
    assign accept  = (state_q == ST_IDLE) && req_valid;
    assign capture = (state_q == ST_RD_ACCESS) && phase_last;
    assign ready   = (state_q == ST_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    // registered strobes, decoded from the state being entered
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n  <= 1'b1;
            cs    <= 1'b0;
            we_n  <= 1'b1;
            oe_n  <= 1'b1;
            drive <= 1'b0;
            done  <= 1'b0;
        end else begin
            cs_n  <= !(state_n inside {ST_RD_ACCESS, ST_WR_SETUP, ST_WR_PULSE, ST_WR_HOLD});
            cs    <=  (state_n inside {ST_RD_ACCESS, ST_WR_SETUP, ST_WR_PULSE, ST_WR_HOLD});
            we_n  <= !(state_n == ST_WR_PULSE);
            oe_n  <= !(state_n == ST_RD_ACCESS);
            drive <=  (state_n inside {ST_WR_SETUP, ST_WR_PULSE, ST_WR_HOLD});
            done  <=  (state_q != ST_IDLE) && (state_n == ST_IDLE);
        end
    end

    AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !oe_n)); // R6
    AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !(drive && !oe_n)); // R6
    AST_WE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> (!cs_n && cs && drive)); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !ready); // R2
    AST_STANDBY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && !cs)); // R10

endmodule

// File: rtl/sramc_datapath.sv
module sramc_datapath #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              capture,
    input  logic [DATA_W-1:0] mem_din,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dout,
    output logic [DATA_W-1:0] rsp_rdata
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_addr <= '0;
            mem_dout <= '0;
        end else if (accept) begin
            mem_addr <= req_addr;
            mem_dout <= req_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_rdata <= '0;
        end else if (capture) begin
            rsp_rdata <= mem_din;
        end
    end

endmodule

// File: rtl/sramc_ctrl.sv
module sramc_ctrl
    import sramc_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter int DATA_W     = 8,
    parameter int CYC_ACCESS = 2,
    parameter int CYC_WP     = 2,
    parameter int CYC_DW     = 1,
    parameter int CYC_HOLD   = 1,
    parameter int CYC_TURN   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_cs,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dout,
    input  logic [DATA_W-1:0] mem_din,
    output logic              mem_drive
);

    localparam int LEN_PULSE = int'(larger_of(CYC_WP, CYC_DW));
    localparam int MAX_LEN   = int'(larger_of(larger_of(CYC_ACCESS, CYC_TURN),
                                              larger_of(LEN_PULSE, CYC_HOLD)));
    localparam int CNT_W     = $clog2(MAX_LEN + 1);

    logic             load, phase_last, accept, capture;
    logic [CNT_W-1:0] load_val;

    sramc_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .last     (phase_last)
    );

    sramc_fsm #(
        .CNT_W      (CNT_W),
        .LEN_ACCESS (CYC_ACCESS),
        .LEN_TURN   (CYC_TURN),
        .LEN_PULSE  (LEN_PULSE),
        .LEN_HOLD   (CYC_HOLD)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .phase_last (phase_last),
        .load       (load),
        .load_val   (load_val),
        .accept     (accept),
        .capture    (capture),
        .ready      (req_ready),
        .done       (rsp_done),
        .cs_n       (mem_cs_n),
        .cs         (mem_cs),
        .we_n       (mem_we_n),
        .oe_n       (mem_oe_n),
        .drive      (mem_drive)
    );

    sramc_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .capture   (capture),
        .mem_din   (mem_din),
        .mem_addr  (mem_addr),
        .mem_dout  (mem_dout),
        .rsp_rdata (rsp_rdata)
    );

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cs && $past(mem_cs)) |-> $stable(mem_addr)); // R7
    AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && !$past(mem_we_n)) |-> $stable(mem_dout)); // R7
    AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(rsp_rdata)); // R8

endmodule

// File: tb/test_sramc_ctrl.sv
module test_sramc_ctrl;

    localparam int ACC = 2, WP = 2, DW = 1, HOLD = 1, TURN = 1;
    localparam int PULSE = (WP > DW) ? WP : DW;
    localparam int LAT_RD = ACC + TURN;
    localparam int LAT_WR = 1 + PULSE + HOLD;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [12:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic req_ready, rsp_done, mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_drive;
    logic [7:0] rsp_rdata, mem_dout;
    logic [7:0] mem_din = 8'hEE;
    logic [12:0] mem_addr;

    int n_checks = 0, n_fail = 0, cyc = 0;
    bit finished = 1'b0;

    typedef struct { bit is_rd; logic [12:0] a; logic [7:0] d; int acc; } item_t;
    item_t exp_q[$];
    logic [7:0] shadow [int];
    logic [7:0] mdl [int];
    logic [7:0] last_rd = 8'h00;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sramc_ctrl #(.CYC_ACCESS(ACC), .CYC_WP(WP), .CYC_DW(DW), .CYC_HOLD(HOLD), .CYC_TURN(TURN)) i_sramc_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_cs_n(mem_cs_n), .mem_cs(mem_cs), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_dout(mem_dout), .mem_din(mem_din), .mem_drive(mem_drive)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // behavioural memory with rule checks
    int we_cnt = 0, oe_gap = 0;
    bit seen_oe = 0;
    logic [12:0] we_addr;
    logic [7:0]  we_data;
    always @(negedge clk) begin
        if (rst_n) begin
            automatic bit sel = !mem_cs_n && mem_cs;
            if (!mem_we_n) begin
                check(mem_oe_n, "R6 oe high during write", mem_oe_n, 1);
                check(sel && mem_drive, "R5 strobe needs selects and drive", {sel, mem_drive}, 3);
                if (we_cnt == 0) begin
                    we_addr = mem_addr; we_data = mem_dout;
                end else begin
                    check(mem_addr == we_addr, "R7 address stable", mem_addr, we_addr);
                    check(mem_dout == we_data, "R7 data stable", mem_dout, we_data);
                end
                if (sel) mdl[int'(mem_addr)] = mem_dout;
                we_cnt++;
            end else if (we_cnt != 0) begin
                check(we_cnt == PULSE, "R5 strobe width", we_cnt, PULSE);
                we_cnt = 0;
            end
            if (mem_drive && sel && !mem_oe_n)
                check(1'b0, "R6 bus contention", 1, 0);
            if (!mem_oe_n) begin
                seen_oe = 1; oe_gap = 0;
            end else if (seen_oe && mem_drive) begin
                check(oe_gap >= TURN + 1, "R4 turnaround gap", oe_gap, TURN + 1);
                seen_oe = 0;
            end else if (seen_oe) begin
                oe_gap++;
            end
            if (sel && !mem_oe_n && mem_we_n)
                mem_din <= mdl.exists(int'(mem_addr)) ? mdl[int'(mem_addr)] : 8'h00;
            else
                mem_din <= 8'hEE;
        end
    end

    // monitor: pops expected completions
    always @(negedge clk) begin
        if (rst_n && rsp_done) begin
            check(mem_cs_n && !mem_cs, "R10 standby at completion", {mem_cs_n, mem_cs}, 2'b10);
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected completion", 1, 0);
            end else begin
                automatic item_t it = exp_q.pop_front();
                if (it.is_rd) begin
                    check(cyc - it.acc == LAT_RD, "R3 read latency", cyc - it.acc, LAT_RD);
                    check(rsp_rdata == it.d, "R9 read data", rsp_rdata, it.d);
                    last_rd = rsp_rdata;
                end else begin
                    check(cyc - it.acc == LAT_WR, "R5 write latency", cyc - it.acc, LAT_WR);
                    check(rsp_rdata == last_rd, "R8 rdata held over write", rsp_rdata, last_rd);
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && rsp_done) begin
            @(negedge clk);
            check(!rsp_done, "R8 done one cycle", rsp_done, 0);
        end
    end

    task automatic do_op(input bit wr, input logic [12:0] a, input logic [7:0] d);
        item_t it;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        it.is_rd = !wr; it.a = a; it.acc = cyc + 1;
        if (wr) begin
            it.d = d; shadow[int'(a)] = d;
        end else begin
            it.d = shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00;
        end
        exp_q.push_back(it);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        check(mem_cs_n && !mem_cs && mem_we_n && mem_oe_n && !mem_drive, "R1 reset strobes",
              {mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_drive}, 5'b10110);
        check(req_ready && !rsp_done, "R1 reset handshake", {req_ready, rsp_done}, 2'b10);
        rst_n = 1'b1;
        @(negedge clk);

        do_op(1, 13'h0000, 8'hA5);
        do_op(1, 13'h1FFF, 8'h3C);
        do_op(1, 13'h0ABC, 8'h77);
        do_op(0, 13'h0000, 8'h00);
        do_op(0, 13'h1FFF, 8'h00);
        do_op(0, 13'h0ABC, 8'h00);
        // write right after read: turnaround
        do_op(1, 13'h0123, 8'h5A);
        do_op(0, 13'h0123, 8'h00);
        do_op(1, 13'h0123, 8'hC3);
        do_op(0, 13'h0123, 8'h00);
        for (int i = 0; i < 16; i++) do_op(1, 13'(i * 509 + 7), 8'(i * 37 + 1));
        for (int i = 15; i >= 0; i--) do_op(0, 13'(i * 509 + 7), 8'h00);

        // R2: request raised while busy and withdrawn before idle is ignored
        do_op(1, 13'h0400, 8'h11);
        check(!req_ready, "R2 ready low while busy", req_ready, 0);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 13'h0555; req_wdata = 8'hFF;
        @(negedge clk);
        req_valid = 1'b0;
        do_op(0, 13'h0555, 8'h00);
        do_op(0, 13'h0400, 8'h00);

        for (int k = 0; k < 200 && exp_q.size() != 0; k++) @(negedge clk);
        check(exp_q.size() == 0, "R2 all completions seen", exp_q.size(), 0);
        repeat (3) @(negedge clk);
        // R1: idle standby again
        check(mem_cs_n && !mem_cs && mem_we_n && mem_oe_n && !mem_drive && req_ready,
              "R1 idle standby", {mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_drive}, 5'b10110);
        finish_up();
    end

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        finish_up();
    end

endmodule